// File: doc/BRIEF.md
# Two-Beat Burst Memory with Separate Read and Write Ports

This block is an on-chip synchronous memory that behaves like a quad-data-rate style static RAM, reduced to one clock. It has a read port and a write port that work independently, each with its own active-low select and address, both sampled on the rising clock edge. A transaction on either port always moves a pair of words: a low beat and a high beat. The two halves of a double-rate data bus are presented side by side as two word-wide lanes within a single cycle.

The address on each port names a word pair. The low beat lives at the even word of the pair and the high beat at the odd word. Writes carry a separate active-low byte-lane enable vector for each beat. Reads are pipelined: the pair comes back with a valid flag. While no read data is due the data outputs are forced to zero, which stands in for releasing the bus. If a read and a write in the same cycle target the same pair, the read returns the contents from before that write.

Top module: `pairburst_sram`

## Requirements
- R1: While `rstN` is low and after it rises, with no read requested, `rdValid` is 0 and both read lanes are 0.
- R2: A burst on address `a` places the low beat at word `2a` and the high beat at word `2a+1`. A later read of `a` returns word `2a` on `rdDataLo` and word `2a+1` on `rdDataHi`.
- R3: Bit `i` of `wrByteEnLoN` or `wrByteEnHiN`, when 0, writes bits `[9i+8:9i]` of that beat's word. When 1, that lane of the stored word keeps its value. The masks of the two beats are independent.
- R4: A read sampled at rising edge `k` (`rdSelN` low) drives `rdValid` high and presents its pair for exactly the cycle from edge `k+1` to edge `k+2`.
- R5: In any cycle that carries no read data, `rdValid` is 0 and both read lanes are 0.
- R6: When a read and a write sampled at the same edge target the same pair, the read returns the data stored before that write.
- R7: Reads requested on consecutive edges give `rdValid` high on consecutive cycles, with no idle gap.
- R8: A read and a write to different pairs, sampled at the same edge, both take full effect.
- R9: A read sampled at the edge after a write's edge returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the control and output registers |
| rdSelN | input | 1 | Active-low read request |
| rdAddr | input | ADDR_W | Read pair address |
| wrSelN | input | 1 | Active-low write request |
| wrAddr | input | ADDR_W | Write pair address |
| wrDataLo | input | LANES*LANE_W | Low-beat write word |
| wrDataHi | input | LANES*LANE_W | High-beat write word |
| wrByteEnLoN | input | LANES | Active-low lane enables for the low beat |
| wrByteEnHiN | input | LANES | Active-low lane enables for the high beat |
| rdDataLo | output | LANES*LANE_W | Low-beat read word, zero when idle |
| rdDataHi | output | LANES*LANE_W | High-beat read word, zero when idle |
| rdValid | output | 1 | Read pair present this cycle |

## Verification
A stuck or misaligned pending-read flag shows up at `rdValid` two edges after the request. It appears either as a missing valid or as a valid with no request behind it. A wrong captured address or a swapped beat index appears as a data mismatch in the same cycle that the pair is presented. A lane mask that is wrongly decoded only shows when that pair is read back, so every mask combination is written and then read on the very next edge. A write that commits one edge too early shows up only in a same-pair read and write, so that collision is exercised on every pair.

// File: rtl/pairburst_pkg.sv
package pairburst_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capRd;   // latch read address this edge
    logic capWr;   // latch write address, data and masks this edge
    logic fireRd;  // a latched read is due: load output lanes
    logic fireWr;  // a latched write is due: commit to the array
  } sramStrb_t;
endpackage

// File: rtl/pairburst_ctrl.sv
module pairburst_ctrl
  import pairburst_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdSelN,
  input  logic      wrSelN,
  output sramStrb_t strb,
  output logic      rdValid
);
  logic rdPendQ, wrPendQ, rdValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPendQ  <= 1'b0;
      wrPendQ  <= 1'b0;
      rdValidQ <= 1'b0;
    end else begin
      rdPendQ  <= !rdSelN;
      wrPendQ  <= !wrSelN;
      rdValidQ <= rdPendQ;
    end
  end

  always_comb begin
    strb.capRd  = !rdSelN;
    strb.capWr  = !wrSelN;
    strb.fireRd = rdPendQ;
    strb.fireWr = wrPendQ;
  end

  assign rdValid = rdValidQ;

  // R4: request at an edge yields valid two edges later
  p_read_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rdSelN |-> ##2 rdValid);

  // R5: no request means no valid two edges later
  p_idle_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdSelN |-> ##2 !rdValid);

  // R7: two consecutive requests give two consecutive valid cycles
  p_no_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!rdSelN ##1 !rdSelN) |=> (rdValid ##1 rdValid));
endmodule

// File: rtl/pairburst_data.sv
module pairburst_data
  import pairburst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES,
  localparam int DEPTH  = 2 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStrb_t         strb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrDataLo,
  input  logic [WORD_W-1:0] wrDataHi,
  input  logic [LANES-1:0]  wrByteEnLoN,
  input  logic [LANES-1:0]  wrByteEnHiN,
  input  logic              rdValid,
  output logic [WORD_W-1:0] rdDataLo,
  output logic [WORD_W-1:0] rdDataHi
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rdAddrQ, wrAddrQ;
  logic [WORD_W-1:0] wrLoQ, wrHiQ;
  logic [LANES-1:0]  beLoQ, beHiQ;
  logic [ADDR_W:0]   rdEven, rdOdd, wrEven, wrOdd;

  assign rdEven = {rdAddrQ, 1'b0};
  assign rdOdd  = {rdAddrQ, 1'b1};
  assign wrEven = {wrAddrQ, 1'b0};
  assign wrOdd  = {wrAddrQ, 1'b1};

  // Request capture stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddrQ <= '0;
      wrAddrQ <= '0;
      wrLoQ   <= '0;
      wrHiQ   <= '0;
      beLoQ   <= '1;
      beHiQ   <= '1;
    end else begin
      if (strb.capRd) rdAddrQ <= rdAddr;
      if (strb.capWr) begin
        wrAddrQ <= wrAddr;
        wrLoQ   <= wrDataLo;
        wrHiQ   <= wrDataHi;
        beLoQ   <= wrByteEnLoN;
        beHiQ   <= wrByteEnHiN;
      end
    end
  end

  // Array commit, one lane at a time per beat
  always_ff @(posedge clk) begin
    if (strb.fireWr) begin
      for (int l = 0; l < LANES; l++) begin
        if (!beLoQ[l]) mem[wrEven][l*LANE_W +: LANE_W] <= wrLoQ[l*LANE_W +: LANE_W];
        if (!beHiQ[l]) mem[wrOdd][l*LANE_W +: LANE_W]  <= wrHiQ[l*LANE_W +: LANE_W];
      end
    end
  end

  // Output lanes: array read happens before the same-edge commit lands
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataLo <= '0;
      rdDataHi <= '0;
    end else if (strb.fireRd) begin
      rdDataLo <= mem[rdEven];
      rdDataHi <= mem[rdOdd];
    end else begin
      rdDataLo <= '0;
      rdDataHi <= '0;
    end
  end

  // R5: lanes are released whenever no pair is presented
  p_release_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdDataLo == '0 && rdDataHi == '0));

  // R3: a fully masked low beat leaves its word untouched
  p_mask_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fireWr && (&beLoQ)) |=> (mem[$past(wrEven)] == $past(mem[wrEven])));
endmodule

// File: rtl/pairburst_sram.sv
module pairburst_sram
  import pairburst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdSelN,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrSelN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrDataLo,
  input  logic [WORD_W-1:0] wrDataHi,
  input  logic [LANES-1:0]  wrByteEnLoN,
  input  logic [LANES-1:0]  wrByteEnHiN,
  output logic [WORD_W-1:0] rdDataLo,
  output logic [WORD_W-1:0] rdDataHi,
  output logic              rdValid
);
  sramStrb_t strb;

  pairburst_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rdSelN  (rdSelN),
    .wrSelN  (wrSelN),
    .strb    (strb),
    .rdValid (rdValid)
  );

  pairburst_data #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rdAddr      (rdAddr),
    .wrAddr      (wrAddr),
    .wrDataLo    (wrDataLo),
    .wrDataHi    (wrDataHi),
    .wrByteEnLoN (wrByteEnLoN),
    .wrByteEnHiN (wrByteEnHiN),
    .rdValid     (rdValid),
    .rdDataLo    (rdDataLo),
    .rdDataHi    (rdDataHi)
  );
endmodule

// File: tb/pairburst_sram_tb.sv
`timescale 1ns/1ps
module pairburst_sram_tb;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int WW = LW * NL;
  localparam int PAIRS = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdSelN = 1'b1, wrSelN = 1'b1;
  logic [AW-1:0] rdAddr = '0, wrAddr = '0;
  logic [WW-1:0] wrDataLo = '0, wrDataHi = '0;
  logic [NL-1:0] wrByteEnLoN = '1, wrByteEnHiN = '1;
  logic [WW-1:0] rdDataLo, rdDataHi;
  logic rdValid;

  always #5 clk = ~clk;

  pairburst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_dut (
    .clk(clk), .rstN(rstN), .rdSelN(rdSelN), .rdAddr(rdAddr),
    .wrSelN(wrSelN), .wrAddr(wrAddr), .wrDataLo(wrDataLo), .wrDataHi(wrDataHi),
    .wrByteEnLoN(wrByteEnLoN), .wrByteEnHiN(wrByteEnHiN),
    .rdDataLo(rdDataLo), .rdDataHi(rdDataHi), .rdValid(rdValid)
  );

  int total = 0;
  int bad = 0;
  logic [WW-1:0] refMem [2*PAIRS];

  // two-deep expectation pipeline
  bit            e1V = 0, e2V = 0;
  logic [WW-1:0] e1Lo, e1Hi, e2Lo, e2Hi;
  string         e1Tag = "", e2Tag = "";

  function automatic logic [WW-1:0] pat(input int a, input int k);
    return WW'((a * 37 + k * 1013 + 5) % (1 << WW));
  endfunction

  task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkOut();
    if (e2V) begin
      chk("R4 valid", WW'(rdValid), WW'(1));
      chk({e2Tag, " lo"}, rdDataLo, e2Lo);
      chk({e2Tag, " hi"}, rdDataHi, e2Hi);
    end else begin
      chk("R5 valid", WW'(rdValid), WW'(0));
      chk("R5 lanes", rdDataLo | rdDataHi, '0);
    end
  endtask

  task automatic step(input bit doRd, input int ra, input bit doWr, input int wa,
                      input logic [WW-1:0] dLo, input logic [WW-1:0] dHi,
                      input logic [NL-1:0] mLo, input logic [NL-1:0] mHi,
                      input string tag);
    @(negedge clk);
    checkOut();
    e2V = e1V; e2Lo = e1Lo; e2Hi = e1Hi; e2Tag = e1Tag;
    rdSelN = !doRd; rdAddr = AW'(ra);
    wrSelN = !doWr; wrAddr = AW'(wa);
    wrDataLo = dLo; wrDataHi = dHi; wrByteEnLoN = mLo; wrByteEnHiN = mHi;
    e1V = doRd; e1Tag = tag;
    if (doRd) begin
      e1Lo = refMem[2*ra];
      e1Hi = refMem[2*ra+1];
    end
    if (doWr) begin
      for (int l = 0; l < NL; l++) begin
        if (!mLo[l]) refMem[2*wa][l*LW +: LW]   = dLo[l*LW +: LW];
        if (!mHi[l]) refMem[2*wa+1][l*LW +: LW] = dHi[l*LW +: LW];
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, '0, '1, '1, "R5");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", WW'(rdValid), WW'(0));
    chk("R1 lanes in reset", rdDataLo | rdDataHi, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", WW'(rdValid), WW'(0));
    chk("R1 lanes after reset", rdDataLo | rdDataHi, '0);

    // R2: fill every pair with distinct beats, full enables
    for (int a = 0; a < PAIRS; a++)
      step(0, 0, 1, a, pat(a, 1), pat(a, 2), '0, '0, "R2");
    // R2 R7: back-to-back readback of every pair
    for (int a = 0; a < PAIRS; a++)
      step(1, a, 0, 0, '0, '0, '1, '1, "R2 R7");
    idle(3);

    // R3 R9: every mask combination on every pair, read on the next edge
    for (int a = 0; a < PAIRS; a++)
      for (int m = 0; m < 16; m++) begin
        step(0, 0, 1, a, pat(a, m + 3), pat(a, m + 40), NL'(m), NL'(m >> 2), "R3 R9");
        step(1, a, 0, 0, '0, '0, '1, '1, "R3 R9");
      end
    idle(2);

    // R6: same-pair read and write in one cycle returns old data
    for (int a = 0; a < PAIRS; a++)
      step(1, a, 1, a, pat(a, 77), pat(a, 78), '0, '0, "R6");
    // R9 again: data written above now visible
    for (int a = 0; a < PAIRS; a++)
      step(1, a, 0, 0, '0, '0, '1, '1, "R6 R9");

    // R8: concurrent read and write to different pairs
    for (int a = 0; a < PAIRS; a++) begin
      step(1, a, 1, (a + 5) % PAIRS, pat(a, 90), pat(a, 91), '0, '0, "R8");
      step(1, (a + 5) % PAIRS, 0, 0, '0, '0, '1, '1, "R8");
    end

    // R4 R5: isolated reads separated by idle cycles
    for (int a = 0; a < 8; a++) begin
      step(1, a * 7 % PAIRS, 0, 0, '0, '0, '1, '1, "R4");
      idle(2);
    end
    idle(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule